// File: doc/BRIEF.md
# Next-Fit Page Range Allocator

The block keeps a bitmap of translation pages (256 by default) and hands out contiguous runs of free pages. An allocate request gives a run length in pages and an alignment mask. The block searches the bitmap one candidate bit per cycle, starting at a next-fit pointer. It answers with the start index of the run, or with a failure. A free request gives a start index and a length, and the block clears those bits one per cycle. A flush request makes the block emit a single flush pulse, but only when earlier activity has left a flush pending.

The lowest 32 pages are held as taken from reset onward. They can never be granted or released. The search begins at the pointer, rounded up to the alignment. If no run fits before the end of the map, the block marks a flush as pending and makes exactly one more pass starting from page 0. A successful grant moves the pointer just past the run. When the run ends at or beyond the last page, the pointer wraps to 0 and a flush becomes pending. A full-flush mode input makes every searched allocation leave a flush pending.

The controller's states are:
- ST_IDLE: waits for a request.
- ST_SCAN: tests one bit per cycle. It moves to ST_MARK on a fit. It restarts at page 0 once when the first pass fails. It moves to ST_DONE when the second pass fails.
- ST_MARK: sets the granted bits.
- ST_CLEAR: clears the freed bits.
- ST_DONE: presents the result for one cycle, then returns to ST_IDLE.

Invalid requests and flush requests go straight from ST_IDLE to ST_DONE.

Top module: `pr_alloc`

## Requirements
- R1: Pages 0 to 31 read as taken from reset. They are never granted, and a free request covering them leaves them taken. After reset, busy, done and flush_pulse are low.
- R2: A request is taken only while busy is low. busy is high from the cycle after acceptance until done. done is high for exactly one cycle, and ok and result_start are valid in that cycle.
- R3: An allocation searches from the next-fit pointer, rounded up to the alignment, toward higher pages. The pointer resets to 0. After a grant the pointer becomes start plus length. The granted run lies wholly inside the map.
- R4: When a grant's start plus length reaches or passes N, the pointer wraps to 0 and a flush becomes pending.
- R5: When no run fits between the pointer and N, a flush becomes pending and the search repeats once from page 0. If that pass also fails, done comes with ok low.
- R6: While full_flush_en is high at acceptance, every searched allocation leaves a flush pending, whether it succeeds or fails.
- R7: A free request clears its run, and those pages become grantable again. If start is at or above the pointer, the pointer moves to start plus length, or to 0 when that sum reaches N. A free never changes the flush state.
- R8: A flush request completes with done. It raises flush_pulse in that same cycle, and clears the pending flag, only when a flush was pending. Otherwise flush_pulse stays low.
- R9: A granted start satisfies start AND mask equal to 0. The mask must be a run of low ones, 2^k-1.
- R10: The following requests finish with ok low and change neither the pointer, the bitmap nor the flush state:
  - an allocation of length 0;
  - an allocation longer than N-32;
  - a free of length 0;
  - a free whose run would pass N.
- R11: The op code encoding is: 2'b01 allocate, 2'b10 free, 2'b11 flush. A request with op 2'b00 is ignored and produces no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_op | input | 2 | 01 allocate, 10 free, 11 flush, 00 none |
| req_len | input | 9 | Run length in pages |
| req_start | input | 8 | Start page of a free |
| req_mask | input | 8 | Alignment mask of an allocation |
| full_flush_en | input | 1 | Every allocation leaves a flush pending |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion strobe |
| ok | output | 1 | Request succeeded, valid with done |
| result_start | output | 8 | Granted start page, valid with done and ok |
| flush_pulse | output | 1 | One-cycle flush command, coincides with done |

## Verification
The embedded properties check several conditions on every cycle:
- done is a single-cycle strobe.
- A flush pulse never leaves the pending flag set.
- Every grant is aligned, lies outside the reserved pages and fits inside the map.

Only the bench's scenarios can show that the search is next-fit and not first-fit. The same holds for these behaviours:
- the wrap and the one retry from page 0 set the pending flag;
- freed pages become grantable again;
- full-flush mode leaves a flush pending;
- invalid requests leave the pointer untouched.

// File: rtl/pr_alloc_pkg.sv
package pr_alloc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MARK,
        ST_CLEAR,
        ST_DONE
    } pr_state_e;

    localparam logic [1:0] OP_NONE  = 2'b00;
    localparam logic [1:0] OP_ALLOC = 2'b01;
    localparam logic [1:0] OP_FREE  = 2'b10;
    localparam logic [1:0] OP_FLUSH = 2'b11;

endpackage

// File: rtl/pr_page_map.sv
module pr_page_map #(
    parameter int NUM_PAGES  = 256,
    parameter int RESV_PAGES = 32,
    localparam int IDX_W     = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val
);

    logic [NUM_PAGES-1:0] taken;

    for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
        if (i < RESV_PAGES) begin : g_resv
            // permanently held pages
            assign taken[i] = 1'b1;
        end else begin : g_free
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    taken[i] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    taken[i] <= wr_val;
                end
            end
        end
    end

    assign rd_bit = taken[rd_idx];

endmodule

// File: rtl/pr_alloc_ctrl.sv
module pr_alloc_ctrl
    import pr_alloc_pkg::*;
#(
    parameter int NUM_PAGES  = 256,
    parameter int RESV_PAGES = 32,
    localparam int IDX_W     = $clog2(NUM_PAGES),
    localparam int LEN_W     = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [LEN_W-1:0] req_len,
    input  logic [IDX_W-1:0] req_start,
    input  logic [IDX_W-1:0] req_mask,
    input  logic             full_flush_en,
    output logic             busy,
    output logic             done,
    output logic             ok,
    output logic [IDX_W-1:0] result_start,
    output logic             flush_pulse,
    output logic [IDX_W-1:0] map_rd_idx,
    input  logic             map_rd_bit,
    output logic             map_wr_en,
    output logic [IDX_W-1:0] map_wr_idx,
    output logic             map_wr_val
);

    localparam int W = IDX_W + 2;
    localparam logic [W-1:0] N_W     = W'(NUM_PAGES);
    localparam logic [W-1:0] MAX_LEN = W'(NUM_PAGES - RESV_PAGES);

    pr_state_e        state;
    logic [1:0]       op_q;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] mask_q;
    logic             ff_q;
    logic [W-1:0]     base_q;
    logic [LEN_W-1:0] off_q;
    logic             pass_q;
    logic [IDX_W-1:0] cur_q;
    logic [LEN_W-1:0] cnt_q;
    logic [IDX_W-1:0] ptr_q;
    logic             need_q;
    logic             ok_q;
    logic [IDX_W-1:0] res_q;
    logic             fire_q;

    logic [W-1:0] probe;
    logic [W-1:0] run_end;
    logic [W-1:0] free_end;

    function automatic logic [W-1:0] align_up(input logic [W-1:0] x,
                                              input logic [W-1:0] m);
        return (x + m) & ~m;
    endfunction

    always_comb begin
        probe    = base_q + W'(off_q);
        run_end  = base_q + W'(len_q);
        free_end = W'(req_start) + W'(req_len);
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_NONE;
            len_q  <= '0;
            mask_q <= '0;
            ff_q   <= 1'b0;
            base_q <= '0;
            off_q  <= '0;
            pass_q <= 1'b0;
            cur_q  <= '0;
            cnt_q  <= '0;
            ptr_q  <= '0;
            need_q <= 1'b0;
            ok_q   <= 1'b0;
            res_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && req_op != OP_NONE) begin
                        op_q   <= req_op;
                        len_q  <= req_len;
                        mask_q <= req_mask;
                        ff_q   <= full_flush_en;
                        fire_q <= 1'b0;
                        ok_q   <= 1'b0;
                        state  <= ST_DONE;
                        unique case (req_op)
                            OP_ALLOC: begin
                                if (req_len != '0 && W'(req_len) <= MAX_LEN) begin
                                    base_q <= align_up(W'(ptr_q), W'(req_mask));
                                    off_q  <= '0;
                                    pass_q <= 1'b0;
                                    state  <= ST_SCAN;
                                end
                            end
                            OP_FREE: begin
                                if (req_len != '0 && free_end <= N_W) begin
                                    ok_q  <= 1'b1;
                                    cur_q <= req_start;
                                    cnt_q <= req_len;
                                    state <= ST_CLEAR;
                                    if (req_start >= ptr_q) begin
                                        ptr_q <= (free_end >= N_W) ? '0 : IDX_W'(free_end);
                                    end
                                end
                            end
                            OP_FLUSH: begin
                                ok_q   <= 1'b1;
                                fire_q <= need_q;
                                need_q <= 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_SCAN: begin
                    if (run_end > N_W) begin
                        need_q <= 1'b1;
                        if (!pass_q) begin
                            pass_q <= 1'b1;
                            base_q <= '0;
                            off_q  <= '0;
                        end else begin
                            ok_q  <= 1'b0;
                            state <= ST_DONE;
                        end
                    end else if (map_rd_bit) begin
                        base_q <= align_up(probe + W'(1), W'(mask_q));
                        off_q  <= '0;
                    end else if (off_q + LEN_W'(1) == len_q) begin
                        ok_q   <= 1'b1;
                        res_q  <= base_q[IDX_W-1:0];
                        cur_q  <= base_q[IDX_W-1:0];
                        cnt_q  <= len_q;
                        ptr_q  <= (run_end >= N_W) ? '0 : IDX_W'(run_end);
                        need_q <= need_q | (run_end >= N_W) | ff_q;
                        state  <= ST_MARK;
                    end else begin
                        off_q <= off_q + LEN_W'(1);
                    end
                end
                ST_MARK, ST_CLEAR: begin
                    cur_q <= cur_q + IDX_W'(1);
                    cnt_q <= cnt_q - LEN_W'(1);
                    if (cnt_q == LEN_W'(1)) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy         = (state != ST_IDLE);
        done         = (state == ST_DONE);
        ok           = ok_q;
        result_start = res_q;
        flush_pulse  = (state == ST_DONE) && fire_q;
        map_rd_idx   = probe[IDX_W-1:0];
        map_wr_en    = (state == ST_MARK) || (state == ST_CLEAR);
        map_wr_idx   = cur_q;
        map_wr_val   = (state == ST_MARK);
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> !need_q);

    // R9
    grant_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && op_q == OP_ALLOC) |-> ((result_start & mask_q) == '0));

    // R1
    grant_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && op_q == OP_ALLOC) |-> (result_start >= IDX_W'(RESV_PAGES)));

    // R3
    grant_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok && op_q == OP_ALLOC) |-> (W'(result_start) + W'(len_q) <= N_W));

endmodule

// File: rtl/pr_alloc.sv
module pr_alloc #(
    parameter int NUM_PAGES  = 256,
    parameter int RESV_PAGES = 32,
    localparam int IDX_W     = $clog2(NUM_PAGES),
    localparam int LEN_W     = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [LEN_W-1:0] req_len,
    input  logic [IDX_W-1:0] req_start,
    input  logic [IDX_W-1:0] req_mask,
    input  logic             full_flush_en,
    output logic             busy,
    output logic             done,
    output logic             ok,
    output logic [IDX_W-1:0] result_start,
    output logic             flush_pulse
);

    logic [IDX_W-1:0] rd_idx;
    logic             rd_bit;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_val;

    pr_alloc_ctrl #(
        .NUM_PAGES (NUM_PAGES),
        .RESV_PAGES(RESV_PAGES)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_len      (req_len),
        .req_start    (req_start),
        .req_mask     (req_mask),
        .full_flush_en(full_flush_en),
        .busy         (busy),
        .done         (done),
        .ok           (ok),
        .result_start (result_start),
        .flush_pulse  (flush_pulse),
        .map_rd_idx   (rd_idx),
        .map_rd_bit   (rd_bit),
        .map_wr_en    (wr_en),
        .map_wr_idx   (wr_idx),
        .map_wr_val   (wr_val)
    );

    pr_page_map #(
        .NUM_PAGES (NUM_PAGES),
        .RESV_PAGES(RESV_PAGES)
    ) map_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_idx(rd_idx),
        .rd_bit(rd_bit),
        .wr_en (wr_en),
        .wr_idx(wr_idx),
        .wr_val(wr_val)
    );

endmodule

// File: tb/pr_alloc_tb_top.sv
module pr_alloc_tb_top;

    localparam logic [1:0] A = 2'b01;
    localparam logic [1:0] F = 2'b10;
    localparam logic [1:0] L = 2'b11;

    typedef struct packed {
        logic [1:0] op;
        logic [8:0] len;
        logic [7:0] start;
        logic [7:0] mask;
        logic       eok;
        logic [7:0] eres;
        logic       epulse;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{A, 9'd4,   8'd0,   8'd0, 1'b1, 8'd32,  1'b0, 4'd3},  // R3
        '{A, 9'd4,   8'd0,   8'd0, 1'b1, 8'd36,  1'b0, 4'd3},  // R3
        '{A, 9'd1,   8'd0,   8'd7, 1'b1, 8'd40,  1'b0, 4'd9},  // R9
        '{A, 9'd2,   8'd0,   8'd7, 1'b1, 8'd48,  1'b0, 4'd9},  // R9
        '{L, 9'd0,   8'd0,   8'd0, 1'b1, 8'd0,   1'b0, 4'd8},  // R8
        '{F, 9'd4,   8'd32,  8'd0, 1'b1, 8'd0,   1'b0, 4'd7},  // R7
        '{A, 9'd4,   8'd0,   8'd0, 1'b1, 8'd50,  1'b0, 4'd3},  // R3
        '{A, 9'd202, 8'd0,   8'd0, 1'b1, 8'd54,  1'b0, 4'd4},  // R4
        '{L, 9'd0,   8'd0,   8'd0, 1'b1, 8'd0,   1'b1, 4'd4},  // R4
        '{L, 9'd0,   8'd0,   8'd0, 1'b1, 8'd0,   1'b0, 4'd8},  // R8
        '{A, 9'd4,   8'd0,   8'd0, 1'b1, 8'd32,  1'b0, 4'd7},  // R7
        '{A, 9'd8,   8'd0,   8'd0, 1'b0, 8'd0,   1'b0, 4'd5},  // R5
        '{L, 9'd0,   8'd0,   8'd0, 1'b1, 8'd0,   1'b1, 4'd5},  // R5
        '{A, 9'd7,   8'd0,   8'd0, 1'b1, 8'd41,  1'b0, 4'd3},  // R3
        '{F, 9'd10,  8'd100, 8'd0, 1'b1, 8'd0,   1'b0, 4'd7},  // R7
        '{A, 9'd5,   8'd0,   8'd0, 1'b1, 8'd100, 1'b0, 4'd5},  // R5
        '{L, 9'd0,   8'd0,   8'd0, 1'b1, 8'd0,   1'b1, 4'd5},  // R5
        '{A, 9'd0,   8'd0,   8'd0, 1'b0, 8'd0,   1'b0, 4'd10}, // R10
        '{A, 9'd225, 8'd0,   8'd0, 1'b0, 8'd0,   1'b0, 4'd10}, // R10
        '{L, 9'd0,   8'd0,   8'd0, 1'b1, 8'd0,   1'b0, 4'd10}, // R10
        '{F, 9'd10,  8'd250, 8'd0, 1'b0, 8'd0,   1'b0, 4'd10}, // R10
        '{A, 9'd5,   8'd0,   8'd0, 1'b1, 8'd105, 1'b0, 4'd7}   // R7
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [8:0] req_len = '0;
    logic [7:0] req_start = '0;
    logic [7:0] req_mask = '0;
    logic       full_flush_en = 1'b0;
    logic       busy, done, ok, flush_pulse;
    logic [7:0] result_start;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pr_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_len(req_len), .req_start(req_start), .req_mask(req_mask),
        .full_flush_en(full_flush_en), .busy(busy), .done(done), .ok(ok),
        .result_start(result_start), .flush_pulse(flush_pulse)
    );

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        n_run++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic [8:0] len,
                           input logic [7:0] start, input logic [7:0] mask,
                           input logic ff, output logic r_ok,
                           output logic [7:0] r_res, output logic r_pulse);
        bit seen;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_len = len;
        req_start = start; req_mask = mask; full_flush_en = ff;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b00;
        check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
        seen = 1'b0;
        r_ok = 1'b0; r_res = '0; r_pulse = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            if (done) begin
                seen = 1'b1;
                r_ok = ok; r_res = result_start; r_pulse = flush_pulse;
                break;
            end
            @(negedge clk);
        end
        check(seen, "R2 done seen", int'(seen), 1);
        @(negedge clk);
        check(done == 1'b0, "R2 done one cycle", int'(done), 0);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic r_ok, r_pulse;
        logic [7:0] r_res;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !flush_pulse, "R1 reset outputs idle",
              int'({busy, done, flush_pulse}), 0);

        for (int v = 0; v < NV; v++) begin
            run_req(VEC[v].op, VEC[v].len, VEC[v].start, VEC[v].mask, 1'b0,
                    r_ok, r_res, r_pulse);
            check(r_ok == VEC[v].eok, $sformatf("R%0d vec%0d ok", VEC[v].rq, v),
                  int'(r_ok), int'(VEC[v].eok));
            if (VEC[v].op == A && VEC[v].eok)
                check(r_res == VEC[v].eres, $sformatf("R%0d vec%0d start", VEC[v].rq, v),
                      int'(r_res), int'(VEC[v].eres));
            check(r_pulse == VEC[v].epulse, $sformatf("R%0d vec%0d pulse", VEC[v].rq, v),
                  int'(r_pulse), int'(VEC[v].epulse));
        end

        // R1: reserved pages survive a free and reset restores them
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 idle after reset", int'({busy, done}), 0);
        run_req(F, 9'd8, 8'd0, 8'd0, 1'b0, r_ok, r_res, r_pulse);
        run_req(A, 9'd1, 8'd0, 8'd0, 1'b0, r_ok, r_res, r_pulse);
        check(r_ok && r_res == 8'd32, "R1 reserved not granted", int'(r_res), 32);

        // R6: full-flush mode leaves a flush pending
        run_req(A, 9'd1, 8'd0, 8'd0, 1'b1, r_ok, r_res, r_pulse);
        check(r_res == 8'd33, "R6 grant start", int'(r_res), 33);
        run_req(L, 9'd0, 8'd0, 8'd0, 1'b0, r_ok, r_res, r_pulse);
        check(r_pulse == 1'b1, "R6 flush pending", int'(r_pulse), 1);
        run_req(A, 9'd1, 8'd0, 8'd0, 1'b0, r_ok, r_res, r_pulse);
        check(r_res == 8'd34, "R6 grant start off", int'(r_res), 34);
        run_req(L, 9'd0, 8'd0, 8'd0, 1'b0, r_ok, r_res, r_pulse);
        check(r_pulse == 1'b0, "R6 no flush when off", int'(r_pulse), 0);

        // R11: op 00 is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_len = 9'd3;
        begin
            bit any_done;
            any_done = 1'b0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (done || busy) any_done = 1'b1;
            end
            req_valid = 1'b0;
            check(!any_done, "R11 op none ignored", int'(any_done), 0);
        end
        run_req(A, 9'd1, 8'd0, 8'd0, 1'b0, r_ok, r_res, r_pulse);
        check(r_res == 8'd35, "R11 state unchanged", int'(r_res), 35);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule